// File: doc/BRIEF.md
# Calibrated Time-of-Day Counter

This block keeps the time of day as seconds, minutes and hours. It counts clock-enable pulses from one of three oscillator sources. These pulses arrive already synchronised into the system clock domain, and a two-bit select picks the source. A prescaler turns the selected pulses into one-second events. Software sets the length of one second as a reload count of source pulses. A signed trim is added to that count once per second, so the average rate can be corrected when the oscillator runs fast or slow.

The three time fields can be written directly. Writing a field restarts the sub-second prescaler, so the new time begins on a clean second boundary. Five periodic events each set their own sticky flag: half second, second, minute, hour and day. Each flag has its own enable into a single interrupt line. A flag stays set until a 1 is written to its clear bit.

Top module: `rtc_calib_top`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, the time reads 00:00:00, all flags are 0 and `irq_o` is 0.
- R2: `src_sel_i` selects which pulse advances the prescaler: 0 = `tick_sub_i`, 1 = `tick_main_i`, 2 = `tick_rc_i`, 3 = no source. Pulses on unselected inputs have no effect, and with code 3 the prescaler and the time hold.
- R3: One second lasts L selected pulses. L = `reload_i` + `trim_i`, where `trim_i` is read as a two's-complement signed value. If that sum is below 2, L is 2.
- R4: A half-second event occurs on the pulse that completes floor(L/2) pulses of the current second. The second event, which occurs on the pulse that completes L pulses, also counts as a half-second event.
- R5: `sec_o` counts 0 to 59 and wraps from 59 to 0. The wrap is a minute event and advances `min_o`.
- R6: `min_o` counts 0 to 59 and wraps from 59 to 0. The wrap is an hour event and advances `hour_o`.
- R7: `hour_o` counts 0 to 23 and wraps from 23 to 0. The wrap is a day event.
- R8: A cycle with `wr_en_i` high and `wr_sel_i` = 0 (seconds), 1 (minutes) or 2 (hours) loads `wr_data_i` into that field, clears the prescaler, and suppresses every event in that cycle. The write is ignored, with no load and no prescaler clear, when `wr_sel_i` = 3, when seconds or minutes data exceeds 59, or when hours data exceeds 23.
- R9: `irq_flags_o` bit 0 = half second, bit 1 = second, bit 2 = minute, bit 3 = hour, bit 4 = day. A flag is set by its event and held until a cycle with the matching `irq_clr_i` bit high. An event in the same cycle as the clear leaves the flag set.
- R10: `irq_o` is high exactly when some flag is set and its `irq_en_i` bit is high. It follows `irq_en_i` in the same cycle. Flags are set regardless of their enable.
- R11: Time fields and flags change at the clock edge that samples the qualifying pulse or write, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Pulse source select |
| tick_sub_i | input | 1 | Sub oscillator pulse (clock enable) |
| tick_main_i | input | 1 | Main oscillator pulse (clock enable) |
| tick_rc_i | input | 1 | RC oscillator pulse (clock enable) |
| reload_i | input | PRESC_W | Nominal pulses per second |
| trim_i | input | CAL_W | Signed per-second correction |
| wr_en_i | input | 1 | Time field write strobe |
| wr_sel_i | input | 2 | Field to write |
| wr_data_i | input | 6 | Value to write |
| irq_en_i | input | 5 | Per-flag interrupt enables |
| irq_clr_i | input | 5 | Write-one-to-clear flag bits |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| irq_flags_o | output | 5 | Sticky event flags |
| irq_o | output | 1 | Masked interrupt |

## Verification
A write or a qualifying pulse sampled at a clock edge shows up in the time fields and flags just after that same edge. `irq_o` responds to a change of `irq_en_i` in the same cycle. The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge from the same inputs, and every output is compared on the following falling edge, so each result is checked in the cycle it is due. Directed runs with a pulse on every cycle pin the exact edges: the half-second flag appears after the fifth pulse of a ten-pulse second, and the seconds increment after the tenth.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_IRQ   = 5;
    localparam int FIELD_W   = 6;
    localparam int HOUR_W    = 5;

    localparam int IRQ_HALF  = 0;
    localparam int IRQ_SEC   = 1;
    localparam int IRQ_MIN   = 2;
    localparam int IRQ_HOUR  = 3;
    localparam int IRQ_DAY   = 4;

    typedef enum logic [1:0] {
        SRC_SUB  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_RC   = 2'd2,
        SRC_OFF  = 2'd3
    } rtc_src_e;

    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_NONE = 2'd3
    } rtc_field_e;

    // event bundle, bit order matches the flag register
    typedef struct packed {
        logic day;
        logic hour;
        logic minute;
        logic second;
        logic half;
    } rtc_evt_t;

endpackage

// File: rtl/rtc_src_mux.sv
module rtc_src_mux
    import rtc_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       tick_sub_i,
    input  logic       tick_main_i,
    input  logic       tick_rc_i,
    output logic       tick_o
);

    always_comb begin
        unique case (rtc_src_e'(sel_i))
            SRC_SUB:  tick_o = tick_sub_i;
            SRC_MAIN: tick_o = tick_main_i;
            SRC_RC:   tick_o = tick_rc_i;
            default:  tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W = 16,
    parameter int CAL_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] reload_i,
    input  logic [CAL_W-1:0]   trim_i,
    output logic               half_o,
    output logic               sec_o
);

    localparam int LEN_W = PRESC_W + 2;
    localparam int CNT_W = PRESC_W + 1;
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
    localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } presc_t;

    presc_t st_q, st_d;

    logic signed [LEN_W-1:0] len_raw;
    logic        [LEN_W-1:0] len_u;
    logic        [LEN_W-1:0] half_u;
    logic        [LEN_W-1:0] cnt_ext;

    always_comb begin
        // trimmed second length, never shorter than two pulses
        len_raw = $signed({2'b00, reload_i})
                + $signed({{(LEN_W-CAL_W){trim_i[CAL_W-1]}}, trim_i});
        if (len_raw < $signed(MIN_LEN)) begin
            len_u = MIN_LEN;
        end else begin
            len_u = $unsigned(len_raw);
        end
        half_u  = len_u >> 1;
        cnt_ext = {1'b0, st_q.cnt};

        st_d   = st_q;
        half_o = 1'b0;
        sec_o  = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (cnt_ext == half_u - ONE) begin
                half_o = 1'b1;
            end
            if (cnt_ext >= len_u - ONE) begin
                sec_o    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_evt_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    output logic               wr_ok_o,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [HOUR_W-1:0]  hour_o,
    output logic               min_evt_o,
    output logic               hour_evt_o,
    output logic               day_evt_o
);

    localparam int NUM_FIELDS = 3;
    localparam logic [FIELD_W-1:0] LIMIT [4] = '{6'd59, 6'd59, 6'd23, 6'd0};

    typedef struct packed {
        logic [NUM_FIELDS-1:0][FIELD_W-1:0] val;
    } tk_t;

    tk_t st_q, st_d;
    logic [NUM_FIELDS:0] carry;

    always_comb begin
        wr_ok_o = wr_en_i && (rtc_field_e'(wr_sel_i) != FLD_NONE)
                  && (wr_data_i <= LIMIT[wr_sel_i]);

        st_d     = st_q;
        carry    = '0;
        carry[0] = sec_evt_i && !wr_ok_o;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            carry[i+1] = carry[i] && (st_q.val[i] == LIMIT[i]);
            if (wr_ok_o) begin
                if (wr_sel_i == 2'(i)) begin
                    st_d.val[i] = wr_data_i;
                end
            end else if (carry[i]) begin
                st_d.val[i] = carry[i+1] ? '0 : st_q.val[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o      = st_q.val[0];
    assign min_o      = st_q.val[1];
    assign hour_o     = st_q.val[2][HOUR_W-1:0];
    assign min_evt_o  = carry[1];
    assign hour_evt_o = carry[2];
    assign day_evt_o  = carry[3];

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  rtc_evt_t           evt_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] flags_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] flags;
    } irq_st_t;

    irq_st_t st_q, st_d;
    logic [NUM_IRQ-1:0] evt_vec;
    logic [NUM_IRQ-1:0] flag_nxt;

    assign evt_vec = evt_i;

    // one sticky cell per source; a new event outranks a clear
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
        assign flag_nxt[g] = evt_vec[g] | (st_q.flags[g] & ~clr_i[g]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = flag_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & en_i);

endmodule

// File: rtl/rtc_calib_top.sv
module rtc_calib_top
    import rtc_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int CAL_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         src_sel_i,
    input  logic               tick_sub_i,
    input  logic               tick_main_i,
    input  logic               tick_rc_i,
    input  logic [PRESC_W-1:0] reload_i,
    input  logic [CAL_W-1:0]   trim_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [5:0]         wr_data_i,
    input  logic [4:0]         irq_en_i,
    input  logic [4:0]         irq_clr_i,
    output logic [5:0]         sec_o,
    output logic [5:0]         min_o,
    output logic [4:0]         hour_o,
    output logic [4:0]         irq_flags_o,
    output logic               irq_o
);

    logic     tick;
    logic     wr_ok;
    logic     half_evt;
    logic     sec_evt;
    logic     min_evt;
    logic     hour_evt;
    logic     day_evt;
    rtc_evt_t evt;

    rtc_src_mux u_src (
        .sel_i       (src_sel_i),
        .tick_sub_i  (tick_sub_i),
        .tick_main_i (tick_main_i),
        .tick_rc_i   (tick_rc_i),
        .tick_o      (tick)
    );

    rtc_prescaler #(
        .PRESC_W (PRESC_W),
        .CAL_W   (CAL_W)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .restart_i (wr_ok),
        .reload_i  (reload_i),
        .trim_i    (trim_i),
        .half_o    (half_evt),
        .sec_o     (sec_evt)
    );

    rtc_timekeep u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_evt_i  (sec_evt),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .wr_ok_o    (wr_ok),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .hour_o     (hour_o),
        .min_evt_o  (min_evt),
        .hour_evt_o (hour_evt),
        .day_evt_o  (day_evt)
    );

    always_comb begin
        evt        = '0;
        evt.half   = half_evt | sec_evt;
        evt.second = sec_evt;
        evt.minute = min_evt;
        evt.hour   = hour_evt;
        evt.day    = day_evt;
    end

    rtc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .en_i    (irq_en_i),
        .clr_i   (irq_clr_i),
        .flags_o (irq_flags_o),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/rtc_calib_chk.sv
module rtc_calib_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [1:0] wr_sel_i,
    input logic [5:0] wr_data_i,
    input logic [4:0] irq_clr_i,
    input logic [5:0] sec_o,
    input logic [5:0] min_o,
    input logic [4:0] hour_o,
    input logic [4:0] irq_flags_o,
    input logic       irq_o
);

    a_r5_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o <= 6'd59);

    a_r6_min_range: assert property (@(posedge clk) disable iff (!rst_n)
        min_o <= 6'd59);

    a_r7_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
        hour_o <= 5'd23);

    a_r5_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && sec_o != $past(sec_o)) |->
        (sec_o == $past(sec_o) + 6'd1 || (sec_o == 6'd0 && $past(sec_o) == 6'd59)));

    a_r7_day_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_o == 5'd0 && $past(hour_o) == 5'd23 && !$past(wr_en_i)) |-> irq_flags_o[4]);

    a_r8_sec_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd0 && wr_data_i <= 6'd59) |=> sec_o == $past(wr_data_i));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irq_flags_o) & ~$past(irq_clr_i)) & ~irq_flags_o) == 5'd0));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_flags_o != 5'd0);

endmodule

bind rtc_calib_top rtc_calib_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .irq_clr_i   (irq_clr_i),
    .sec_o       (sec_o),
    .min_o       (min_o),
    .hour_o      (hour_o),
    .irq_flags_o (irq_flags_o),
    .irq_o       (irq_o)
);

// File: tb/rtc_calib_top_bench.sv
module rtc_calib_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic        tick_sub = 1'b0, tick_main = 1'b0, tick_rc = 1'b0;
    logic [15:0] reload = 16'd10;
    logic [7:0]  trim = 8'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [5:0]  wr_data = 6'd0;
    logic [4:0]  irq_en = 5'd0;
    logic [4:0]  irq_clr = 5'd0;
    logic [5:0]  sec_o, min_o;
    logic [4:0]  hour_o, flags_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit force_ticks = 1'b0;
    bit rand_ctl = 1'b0;

    // behavioural model state
    int m_cnt = 0, m_sec = 0, m_min = 0, m_hour = 0;
    int m_flags = 0;

    always #10 clk = ~clk;

    rtc_calib_top u_rtc_calib_top (
        .clk (clk), .rst_n (rst_n), .src_sel_i (src_sel),
        .tick_sub_i (tick_sub), .tick_main_i (tick_main), .tick_rc_i (tick_rc),
        .reload_i (reload), .trim_i (trim),
        .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
        .irq_en_i (irq_en), .irq_clr_i (irq_clr),
        .sec_o (sec_o), .min_o (min_o), .hour_o (hour_o),
        .irq_flags_o (flags_o), .irq_o (irq_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_hour = 0; m_flags = 0;
        end else begin
            int len, ev, lim;
            bit tk, ok;
            len = int'(reload) + int'($signed(trim));
            if (len < 2) len = 2;
            tk = (src_sel == 2'd0) ? tick_sub : (src_sel == 2'd1) ? tick_main :
                 (src_sel == 2'd2) ? tick_rc : 1'b0;
            lim = (wr_sel == 2'd2) ? 23 : 59;
            ok = wr_en && wr_sel != 2'd3 && int'(wr_data) <= lim;
            ev = 0;
            if (ok) begin
                m_cnt = 0;
                if (wr_sel == 2'd0) m_sec = wr_data;
                else if (wr_sel == 2'd1) m_min = wr_data;
                else m_hour = wr_data;
            end else if (tk) begin
                if (m_cnt == len / 2 - 1) ev = ev | 1;
                if (m_cnt >= len - 1) begin
                    m_cnt = 0;
                    ev = ev | 3;
                    m_sec++;
                    if (m_sec == 60) begin
                        m_sec = 0; ev = ev | 4; m_min++;
                        if (m_min == 60) begin
                            m_min = 0; ev = ev | 8; m_hour++;
                            if (m_hour == 24) begin m_hour = 0; ev = ev | 16; end
                        end
                    end
                end else m_cnt++;
            end
            m_flags = (m_flags & ~int'(irq_clr)) | ev;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5 seconds", sec_o, m_sec);
        chk("R6 minutes", min_o, m_min);
        chk("R7 hours", hour_o, m_hour);
        chk("R9 flags", flags_o, m_flags);
        chk("R10 irq", irq_o, ((m_flags & int'(irq_en)) != 0) ? 1 : 0);
    endtask

    task automatic cycle();
        @(negedge clk);
        compare_all();
        wr_en = 1'b0;
        irq_clr = 5'd0;
        if (force_ticks) begin
            tick_sub = 1'b1; tick_main = 1'b1; tick_rc = 1'b1;
        end else begin
            tick_sub = 1'($urandom % 2);
            tick_main = 1'($urandom % 2);
            tick_rc = 1'($urandom % 3 == 0);
        end
        if (rand_ctl) begin
            irq_en = 5'($urandom);
            if ($urandom % 4 == 0) irq_clr = 5'($urandom);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(int sel, int data, bit clr_all);
        cycle();
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 6'(data);
        if (clr_all) irq_clr = 5'h1f;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int held;
        #5;
        chk("R1 reset sec", sec_o, 0);
        chk("R1 reset flags", flags_o, 0);
        chk("R1 reset irq", irq_o, 0);
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        cycle();
        chk("R1 post-reset hour", hour_o, 0);

        // directed: 10-pulse second, pulses every cycle (R3, R4, R11)
        force_ticks = 1'b1;
        wr(0, 0, 1'b1);
        for (int j = 1; j <= 11; j++) begin
            cycle();
            if (j == 5) chk("R4 no half yet", flags_o, 0);
            if (j == 6) chk("R4 half flag", flags_o, 1);
            if (j == 10) chk("R3 second not yet", sec_o, 0);
            if (j == 11) begin
                chk("R3 second after L pulses", sec_o, 1);
                chk("R11 same-edge flags", flags_o, 3);
            end
        end

        // R7 day wrap from 23:59:59
        wr(2, 23, 1'b0);
        wr(1, 59, 1'b0);
        wr(0, 59, 1'b1);
        for (int j = 1; j <= 11; j++) cycle();
        chk("R7 hour wrap", hour_o, 0);
        chk("R7 day flag", flags_o, 31);

        // R8 out-of-range and no-field writes are ignored
        wr(1, 33, 1'b0);
        cycle();
        chk("R8 minute write", min_o, 33);
        wr(0, 60, 1'b0);
        cycle();
        chk("R8 seconds 60 ignored", sec_o, m_sec);
        wr(2, 24, 1'b0);
        wr(3, 5, 1'b0);
        cycle();
        chk("R8 hour 24 ignored", hour_o, 0);

        // R2 source off holds everything
        src_sel = 2'd3;
        run(2);
        held = sec_o;
        run(40);
        chk("R2 source off holds", sec_o, held);

        // random pulses, all sources, trims, random enables and clears
        force_ticks = 1'b0;
        rand_ctl = 1'b1;
        src_sel = 2'd0; run(400);
        trim = 8'd3; src_sel = 2'd1; run(400);
        trim = 8'hFC; src_sel = 2'd2; run(600);
        reload = 16'd2; trim = 8'hFB; src_sel = 2'd0; run(200);
        reload = 16'd3; trim = 8'd0; run(100);
        wr(1, 59, 1'b0); wr(0, 58, 1'b0);
        reload = 16'd2; force_ticks = 1'b1; run(300);
        force_ticks = 1'b0;
        for (int k = 0; k < 20; k++) begin
            wr(k % 4, (k * 7) % 64, 1'b0);
            run(15);
        end
        rand_ctl = 1'b0;
        irq_en = 5'h1f; run(5);
        irq_en = 5'h00; run(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule